// File: doc/BRIEF.md
# Packed SIMD Saturating Adder Unit

This unit does packed integer arithmetic on 32-bit words. It reads two source words and a 4-bit opcode. It returns a registered 32-bit result together with a sticky overflow flag.

Depending on the opcode, each word is treated in one of three ways:
- four independent unsigned bytes;
- two independent signed Q15 halfwords;
- one signed Q31 word.

The operations are:
- add and subtract, in a wrapping form and in a saturating form;
- saturating absolute value;
- an unsigned sum of the four bytes of one source.

Lanes never share a carry or a borrow. The signed saturating forms clamp to the most positive or the most negative lane value. The absolute value of the most negative value becomes the most positive value.

There is no handshake. A new operation can be presented every clock cycle, and its result appears one cycle later. The overflow flag gathers every saturation event until the clear input is pulsed. This lets a caller run a stretch of arithmetic and then test once whether any result was clamped.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low, and after reset until the first operation is captured, `result` is 0 and `ovf_sticky` is 0.
- R2: Opcode 1 (byte add) and opcode 3 (byte subtract) work modulo 256 in each byte lane. Lane k occupies bits [8k+7:8k]. No carry or borrow passes into a neighbouring lane.
- R3: Opcode 2 (saturating unsigned byte add) clamps any lane sum above 0xFF to 0xFF. Opcode 4 (saturating unsigned byte subtract) clamps any lane difference below zero to 0x00.
- R4: Opcode 5 (halfword add) and opcode 7 (halfword subtract) work modulo 2^16 in each halfword lane. Lane 0 occupies bits [15:0] and lane 1 occupies bits [31:16]. No carry or borrow crosses between lanes.
- R5: Opcode 6 (saturating Q15 add) and opcode 8 (saturating Q15 subtract) clamp a positive overflow to 0x7FFF and a negative overflow to 0x8000, lane by lane.
- R6: Opcode 9 (saturating Q15 absolute value of `src_a`) returns |x| for each halfword lane, and maps 0x8000 to 0x7FFF.
- R7: Opcode 10 (saturating Q31 absolute value of `src_a`) returns |x| for the full word, and maps 0x80000000 to 0x7FFFFFFF.
- R8: Opcode 11 (byte sum) returns the unsigned sum of the four bytes of `src_a`, zero-extended to 32 bits.
- R9: `ovf_sticky` rises one cycle after any lane of a saturating opcode (2, 4, 6, 8, 9, 10) is clamped. It then stays high. The wrapping opcodes never set it, even when they overflow.
- R10: A cycle with `ovf_clr` high clears `ovf_sticky` on the next edge. If the operation in that same cycle saturates, the flag is set instead.
- R11: Opcodes 0, 12, 13, 14 and 15 give a result of 0 and leave `ovf_sticky` unchanged.
- R12: An operation presented in one cycle appears on `result` after the next rising clock edge, and it stays there until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation select |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| result | output | 32 | Registered result |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
The operands are chosen so that the low lane carries out (0xF2 + 0xFF) or borrows (0xF2 − 0xFF). If a design let lane boundaries leak, the upper byte would come out as 0xBE or 0xAA instead of 0xBD or 0xAB.

Saturation is tested in three places:
- positive Q15 overflow must give 0x7FFF;
- negative Q15 overflow must give 0x8000;
- the absolute value of the most negative halfword and word must give the most positive value. A design that simply negated these would return 0x8000 or 0x80000000 unchanged.

The flag is also tested for its mode-dependent behaviour. A wrapping overflow must not raise it. An unused opcode must neither clear it nor raise it. A clear issued together with a saturating operation must leave it set.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic        ovf_clr,
  output logic [31:0] result,
  output logic        ovf_sticky
);

  localparam int BL = 8;
  localparam int HL = 16;
  localparam int NB = 32 / BL;
  localparam int NH = 32 / HL;

  localparam logic [3:0] OP_BADD  = 4'd1;
  localparam logic [3:0] OP_BADDS = 4'd2;
  localparam logic [3:0] OP_BSUB  = 4'd3;
  localparam logic [3:0] OP_BSUBS = 4'd4;
  localparam logic [3:0] OP_HADD  = 4'd5;
  localparam logic [3:0] OP_HADDS = 4'd6;
  localparam logic [3:0] OP_HSUB  = 4'd7;
  localparam logic [3:0] OP_HSUBS = 4'd8;
  localparam logic [3:0] OP_HABS  = 4'd9;
  localparam logic [3:0] OP_WABS  = 4'd10;
  localparam logic [3:0] OP_BSUM  = 4'd11;

  logic [31:0] b_add, b_adds, b_sub, b_subs;
  logic [31:0] h_add, h_adds, h_sub, h_subs, h_abs;
  logic [NB-1:0] b_cy, b_bw;
  logic [NH-1:0] h_ovf_a, h_ovf_s, h_ovf_abs;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BL:0] s, d;
    assign s = {1'b0, src_a[k*BL +: BL]} + {1'b0, src_b[k*BL +: BL]};
    assign d = {1'b0, src_a[k*BL +: BL]} - {1'b0, src_b[k*BL +: BL]};
    assign b_cy[k] = s[BL];
    assign b_bw[k] = d[BL];
    assign b_add[k*BL +: BL]  = s[BL-1:0];
    assign b_sub[k*BL +: BL]  = d[BL-1:0];
    assign b_adds[k*BL +: BL] = s[BL] ? {BL{1'b1}} : s[BL-1:0];
    assign b_subs[k*BL +: BL] = d[BL] ? {BL{1'b0}} : d[BL-1:0];
  end

  for (genvar k = 0; k < NH; k++) begin : g_half
    logic [HL-1:0] x, y, nx;
    logic [HL:0]   s, d;
    assign x  = src_a[k*HL +: HL];
    assign y  = src_b[k*HL +: HL];
    assign s  = {x[HL-1], x} + {y[HL-1], y};
    assign d  = {x[HL-1], x} - {y[HL-1], y};
    assign nx = ~x + 1'b1;
    assign h_ovf_a[k]   = s[HL] ^ s[HL-1];
    assign h_ovf_s[k]   = d[HL] ^ d[HL-1];
    assign h_ovf_abs[k] = (x == {1'b1, {(HL-1){1'b0}}});
    assign h_add[k*HL +: HL]  = s[HL-1:0];
    assign h_sub[k*HL +: HL]  = d[HL-1:0];
    assign h_adds[k*HL +: HL] = h_ovf_a[k] ? (s[HL] ? {1'b1, {(HL-1){1'b0}}} : {1'b0, {(HL-1){1'b1}}}) : s[HL-1:0];
    assign h_subs[k*HL +: HL] = h_ovf_s[k] ? (d[HL] ? {1'b1, {(HL-1){1'b0}}} : {1'b0, {(HL-1){1'b1}}}) : d[HL-1:0];
    assign h_abs[k*HL +: HL]  = h_ovf_abs[k] ? {1'b0, {(HL-1){1'b1}}} : (x[HL-1] ? nx : x);
  end

  logic        w_ovf;
  logic [31:0] w_abs;
  assign w_ovf = (src_a == 32'h8000_0000);
  assign w_abs = w_ovf ? 32'h7FFF_FFFF : (src_a[31] ? (~src_a + 32'd1) : src_a);

  logic [31:0] b_sum;
  always_comb begin
    b_sum = '0;
    for (int k = 0; k < NB; k++) b_sum = b_sum + {24'd0, src_a[k*BL +: BL]};
  end

  logic [31:0] nxt;
  logic        sat_now;
  always_comb begin
    nxt = '0;
    sat_now = 1'b0;
    case (op)
      OP_BADD:  nxt = b_add;
      OP_BADDS: begin nxt = b_adds; sat_now = |b_cy;      end
      OP_BSUB:  nxt = b_sub;
      OP_BSUBS: begin nxt = b_subs; sat_now = |b_bw;      end
      OP_HADD:  nxt = h_add;
      OP_HADDS: begin nxt = h_adds; sat_now = |h_ovf_a;   end
      OP_HSUB:  nxt = h_sub;
      OP_HSUBS: begin nxt = h_subs; sat_now = |h_ovf_s;   end
      OP_HABS:  begin nxt = h_abs;  sat_now = |h_ovf_abs; end
      OP_WABS:  begin nxt = w_abs;  sat_now = w_ovf;      end
      OP_BSUM:  nxt = b_sum;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      result     <= nxt;
      ovf_sticky <= (ovf_sticky & ~ovf_clr) | sat_now;
    end
  end

  logic unused_op;
  assign unused_op = (op == 4'd0) || (op > OP_BSUM);

  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> (result == 32'd0 && !ovf_sticky));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  assert_wrap_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_sticky && (op == OP_BADD || op == OP_BSUB || op == OP_HADD || op == OP_HSUB || op == OP_BSUM)) |=> !ovf_sticky);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && unused_op) |=> !ovf_sticky);

  assert_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (unused_op && !ovf_clr) |=> (result == 32'd0 && $stable(ovf_sticky)));

  assert_habs_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HABS) |=> (!result[15] && !result[31]));

  assert_wabs_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WABS) |=> !result[31]);

  assert_bsum_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BSUM) |=> (result[31:10] == 22'd0));

endmodule

// File: tb/tb_simd_sat_alu.sv
module tb_simd_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        ovf_clr = 1'b0;
  logic [31:0] result;
  logic        ovf_sticky;
  int n_run = 0, n_fail = 0;

  simd_sat_alu dut (.clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
                    .ovf_clr(ovf_clr), .result(result), .ovf_sticky(ovf_sticky));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic clr);
    @(negedge clk);
    op = o; src_a = a; src_b = b; ovf_clr = clr;
    @(negedge clk);
    op = 4'd0; ovf_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 result", result, 32'd0);
    chk("R1 flag", {31'd0, ovf_sticky}, 32'd0);
  endtask

  task automatic t_bytes;
    run_op(4'd1, 32'h785634F2, 32'h111189FF, 1'b0);
    chk("R2 byte add", result, 32'h8967BDF1);
    run_op(4'd3, 32'h785634F2, 32'h111189FF, 1'b0);
    chk("R2 byte sub", result, 32'h6745ABF3);
    chk("R9 wrap keeps flag low", {31'd0, ovf_sticky}, 32'd0);
    run_op(4'd2, 32'h785634F2, 32'h111189FF, 1'b0);
    chk("R3 byte add sat", result, 32'h8967BDFF);
    run_op(4'd4, 32'h785634F2, 32'h111189FF, 1'b0);
    chk("R3 byte sub sat", result, 32'h67450000);
  endtask

  task automatic t_halves;
    run_op(4'd0, 32'h0, 32'h0, 1'b1);
    run_op(4'd5, 32'h56781234, 32'h11116F89, 1'b0);
    chk("R4 half add", result, 32'h678981BD);
    chk("R9 wrap overflow no flag", {31'd0, ovf_sticky}, 32'd0);
    run_op(4'd7, 32'h56781234, 32'h11116F89, 1'b0);
    chk("R4 half sub", result, 32'h4567A2AB);
    run_op(4'd6, 32'h56781234, 32'h11116F89, 1'b0);
    chk("R5 half add sat", result, 32'h67897FFF);
    chk("R9 flag set", {31'd0, ovf_sticky}, 32'd1);
    run_op(4'd8, 32'h56788000, 32'h11116F89, 1'b0);
    chk("R5 half sub sat", result, 32'h45678000);
  endtask

  task automatic t_abs;
    run_op(4'd9, 32'h81348000, 32'h0, 1'b0);
    chk("R6 half abs sat", result, 32'h7ECC7FFF);
    run_op(4'd9, 32'h0005FFFF, 32'h0, 1'b0);
    chk("R6 half abs plain", result, 32'h00050001);
    run_op(4'd10, 32'h80000000, 32'h0, 1'b0);
    chk("R7 word abs sat", result, 32'h7FFFFFFF);
    run_op(4'd10, 32'hFFFFFFFE, 32'h0, 1'b0);
    chk("R7 word abs plain", result, 32'h00000002);
  endtask

  task automatic t_sum;
    run_op(4'd11, 32'h785634F2, 32'hFFFFFFFF, 1'b0);
    chk("R8 byte sum", result, 32'h000001F4);
    run_op(4'd11, 32'hFFFFFFFF, 32'h0, 1'b0);
    chk("R8 byte sum max", result, 32'h000003FC);
  endtask

  task automatic t_flag;
    run_op(4'd6, 32'h00007FFF, 32'h00000001, 1'b0);
    chk("R9 flag up", {31'd0, ovf_sticky}, 32'd1);
    run_op(4'd15, 32'h12345678, 32'h12345678, 1'b0);
    chk("R11 unused result", result, 32'd0);
    chk("R11 unused keeps flag", {31'd0, ovf_sticky}, 32'd1);
    run_op(4'd1, 32'hFFFFFFFF, 32'h01010101, 1'b1);
    chk("R10 clear", {31'd0, ovf_sticky}, 32'd0);
    run_op(4'd12, 32'h1, 32'h1, 1'b0);
    chk("R11 unused flag low", {31'd0, ovf_sticky}, 32'd0);
    run_op(4'd2, 32'h000000FF, 32'h00000001, 1'b1);
    chk("R10 set beats clear", {31'd0, ovf_sticky}, 32'd1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op = 4'd1; src_a = 32'h01020304; src_b = 32'h01010101;
    @(posedge clk);
    #1;
    src_a = 32'h0; src_b = 32'h0; op = 4'd0;
    chk("R12 after edge", result, 32'h02030405);
    @(negedge clk);
    chk("R12 held until next edge", result, 32'h02030405);
    @(negedge clk);
    chk("R12 next op", result, 32'd0);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_halves();
    t_abs();
    t_sum();
    t_flag();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule